// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

A 32-bit shift unit for a simple processor datapath. Each request carries an operand, an opcode and a shift amount. It produces the shifted or rotated value and, on request, new negative, zero and carry flags. The unit performs five operations: arithmetic shift right, logical shift left, logical shift right, rotate right, and a one-place rotate right that passes through the carry.

The shift amount comes from one of two sources. The first is a 6-bit immediate field. Each operation has its own legal range for the immediate, and an immediate outside that range is rejected. The second is a byte taken from a register operand. A byte amount may be anything from 0 to 255, and every value in that range has a defined result.

A request is sampled while `start` is high. On the next clock edge the unit pulses `valid` with the new result, or pulses `err` if the request was rejected. The unit keeps its flags between requests. The operand is only read and is never changed.

Top module: `shift_rot_unit`

## Requirements
- R1: Opcodes are ASR=0, LSL=1, LSR=2, ROR=3 and RRX=4. Opcodes 5, 6 and 7 are rejected with `err`.
- R2: A request sampled with `start` high produces exactly one pulse on the next edge: either `valid` or `err`, never both. With no request, neither pulse appears.
- R3: When `amt_sel`=1, the amount is `amt_byte` (0 to 255). For amounts of 32 or more, LSL and LSR give zero and ASR gives 32 copies of bit 31.
- R4: ROR rotates by the amount modulo 32. A byte amount that is a nonzero multiple of 32 returns the operand unchanged.
- R5: When `amt_sel`=0, the legal immediates are ASR 1..32, LSL 0..31, LSR 1..32 and ROR 1..31. An illegal immediate, or an illegal opcode, pulses `err` and leaves `result` and all flags unchanged.
- R6: An amount of zero (LSL immediate 0, or a byte amount of 0 for any shift) passes the operand through and leaves C unchanged.
- R7: C receives the last bit shifted out. LSL by 32 gives C = bit 0, and LSR or ASR by 32 gives C = bit 31. LSL or LSR by more than 32 gives C = 0. ROR gives C = bit 31 of the result.
- R8: RRX puts `carry_in` into bit 31, shifts the operand right by one, and, when flags are written, sets C to operand bit 0. RRX ignores the amount inputs.
- R9: With `set_flags` high on an accepted request, N takes result bit 31 and Z is set exactly when the result is zero.
- R10: With `set_flags` low, N, Z and C keep their values.
- R11: A synchronous active-high `rst` clears `result`, the flags, `valid` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe; inputs are sampled while high |
| op | input | 3 | Operation code |
| amt_sel | input | 1 | 1: amount from `amt_byte`; 0: amount from `imm_amt` |
| imm_amt | input | 6 | Immediate shift amount |
| amt_byte | input | 8 | Low byte of the register holding the amount |
| src | input | 32 | Operand to shift |
| carry_in | input | 1 | Carry shifted into bit 31 by RRX |
| set_flags | input | 1 | Write N, Z and C for this request |
| result | output | 32 | Last accepted result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| valid | output | 1 | One-cycle pulse for an accepted request |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
An accepted request with a zero amount and `set_flags` high does two things in the same cycle. It writes N and Z from the passed-through operand, and it must keep C. The bench first loads a known C with an earlier request. It then issues zero-amount requests with set-flags high, once with an immediate and once with a byte amount, and compares all three flags against the scoreboard model. A second overlap comes from rejected requests placed directly after accepted ones. The `err` pulse must follow straight after a `valid` pulse while `result` and the flags stay as the accepted request left them.

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int W = 32,
  parameter int IMM_W = $clog2(W) + 1,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic              amt_sel,
  input  logic [IMM_W-1:0]  imm_amt,
  input  logic [BYTE_W-1:0] amt_byte,
  input  logic [W-1:0]      src,
  input  logic              carry_in,
  input  logic              set_flags,
  output logic [W-1:0]      result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              valid,
  output logic              err
);
  localparam int SH_W = $clog2(W);
  localparam logic [2:0] OP_ASR = 3'd0;
  localparam logic [2:0] OP_LSL = 3'd1;
  localparam logic [2:0] OP_LSR = 3'd2;
  localparam logic [2:0] OP_ROR = 3'd3;
  localparam logic [2:0] OP_RRX = 3'd4;

  logic [BYTE_W-1:0] amt;
  logic              imm_bad, illegal, amt_zero;
  logic [W:0]        lsl_w, lsr_w, asr_w;
  logic [W-1:0]      rot_w, nxt_res;
  logic [SH_W-1:0]   rot_k;
  logic              nxt_c;

  assign amt      = amt_sel ? amt_byte : BYTE_W'(imm_amt);
  assign amt_zero = (amt == '0);
  assign rot_k    = amt[SH_W-1:0];

  always_comb begin
    case (op)
      OP_ASR, OP_LSR: imm_bad = (imm_amt == '0) || (int'(imm_amt) > W);
      OP_LSL:         imm_bad = (int'(imm_amt) >= W);
      OP_ROR:         imm_bad = (imm_amt == '0) || (int'(imm_amt) >= W);
      default:        imm_bad = 1'b0;
    endcase
  end
  assign illegal = (op > OP_RRX) || (!amt_sel && imm_bad);

  assign lsl_w = {1'b0, src} << amt;
  assign lsr_w = {src, 1'b0} >> amt;
  assign asr_w = $signed({src, 1'b0}) >>> amt;
  assign rot_w = (src >> rot_k) | (src << (W - int'(rot_k)));

  always_comb begin
    nxt_res = src;
    nxt_c   = flag_c;
    if (op == OP_RRX) begin
      nxt_res = {carry_in, src[W-1:1]};
      nxt_c   = src[0];
    end else if (!amt_zero) begin
      case (op)
        OP_ASR: begin nxt_res = asr_w[W:1]; nxt_c = asr_w[0]; end
        OP_LSL: begin nxt_res = lsl_w[W-1:0]; nxt_c = lsl_w[W]; end
        OP_LSR: begin nxt_res = lsr_w[W:1]; nxt_c = lsr_w[0]; end
        default: begin nxt_res = rot_w; nxt_c = rot_w[W-1]; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      valid  <= 1'b0;
      err    <= 1'b0;
    end else begin
      valid <= start && !illegal;
      err   <= start && illegal;
      if (start && !illegal) begin
        result <= nxt_res;
        if (set_flags) begin
          flag_n <= nxt_res[W-1];
          flag_z <= (nxt_res == '0);
          flag_c <= nxt_c;
        end
      end
    end
  end

  p_one_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (valid ^ err));
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!valid && !err));
  p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(start && set_flags) |=> $stable({flag_n, flag_z, flag_c}));
  p_err_keeps_state_r5: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(result) && $stable({flag_n, flag_z, flag_c})));
  p_nz_track_r9: assert property (@(posedge clk) disable iff (rst)
    (start && set_flags && !illegal) |=> (flag_n == result[W-1]) && (flag_z == (result == '0)));
  p_rrx_top_r8: assert property (@(posedge clk) disable iff (rst)
    (start && op == OP_RRX) |=> (valid && result[W-1] == $past(carry_in)));
endmodule

// File: tb/shift_rot_unit_tb_top.sv
module shift_rot_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] op = '0;
  logic amt_sel = 1'b0, carry_in = 1'b0, set_flags = 1'b0;
  logic [5:0] imm_amt = '0;
  logic [7:0] amt_byte = '0;
  logic [31:0] src = '0;
  logic [31:0] result;
  logic flag_n, flag_z, flag_c, valid, err;

  shift_rot_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .amt_sel(amt_sel),
    .imm_amt(imm_amt), .amt_byte(amt_byte), .src(src), .carry_in(carry_in),
    .set_flags(set_flags), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .valid(valid), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic bad;
    logic [31:0] r;
    logic n, z, c;
    string tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic [31:0] m_r = '0;
  logic m_n = 0, m_z = 0, m_c = 0;

  task automatic chk(input logic ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic fr, input logic [5:0] im,
                       input logic [7:0] ab, input logic [31:0] s, input logic ci,
                       input logic sf, input string tag);
    item_t it;
    logic bad;
    int a;
    logic [31:0] r;
    logic c, cupd;
    bad = (o > 3'd4);
    if (!fr) begin
      case (o)
        3'd0, 3'd2: if (im < 1 || im > 32) bad = 1;
        3'd1:       if (im > 31) bad = 1;
        3'd3:       if (im < 1 || im > 31) bad = 1;
        default: ;
      endcase
    end
    a = fr ? int'(ab) : int'(im);
    r = s; c = 1'b0; cupd = 1'b0;
    if (o == 3'd4) begin
      r = {ci, s[31:1]}; c = s[0]; cupd = 1'b1;
    end else if (a != 0) begin
      cupd = 1'b1;
      for (int i = 0; i < a; i++) begin
        case (o)
          3'd0: begin c = r[0];  r = {r[31], r[31:1]}; end
          3'd1: begin c = r[31]; r = {r[30:0], 1'b0}; end
          3'd2: begin c = r[0];  r = {1'b0, r[31:1]}; end
          default: begin c = r[0]; r = {r[0], r[31:1]}; end
        endcase
      end
    end
    if (!bad) begin
      m_r = r;
      if (sf) begin
        m_n = r[31]; m_z = (r == 0);
        if (cupd) m_c = c;
      end
    end
    it.bad = bad; it.r = m_r; it.n = m_n; it.z = m_z; it.c = m_c; it.tag = tag;
    q.push_back(it);
    op = o; amt_sel = fr; imm_amt = im; amt_byte = ab; src = s;
    carry_in = ci; set_flags = sf; start = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && (valid || err)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R2", $sformatf("pulse valid=%0b err=%0b with nothing pending, expected none", valid, err));
      end else begin
        item_t e;
        e = q.pop_front();
        chk(valid == !e.bad && err == e.bad, e.tag,
            $sformatf("valid/err actual %0b/%0b expected %0b/%0b", valid, err, !e.bad, e.bad));
        chk(result == e.r && flag_n == e.n && flag_z == e.z && flag_c == e.c, e.tag,
            $sformatf("res/n/z/c actual %h/%0b%0b%0b expected %h/%0b%0b%0b",
                      result, flag_n, flag_z, flag_c, e.r, e.n, e.z, e.c));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      chk(1'b0, "WDOG", "watchdog expired, actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(result == 0 && {flag_n, flag_z, flag_c} == 3'b000 && !valid && !err, "R11",
        $sformatf("actual res=%h nzc=%0b%0b%0b v=%0b e=%0b expected all zero",
                  result, flag_n, flag_z, flag_c, valid, err));
    // R1 R9 basic operations by immediate
    issue(3'd0, 0, 6'd4, 8'd0, 32'h8000_00F0, 0, 1, "R1_asr");
    issue(3'd1, 0, 6'd31, 8'd0, 32'h0000_0003, 0, 1, "R7_lsl31");
    issue(3'd2, 0, 6'd32, 8'd0, 32'h8000_0001, 0, 1, "R7_lsr32");
    issue(3'd0, 0, 6'd32, 8'd0, 32'h7FFF_FFFF, 0, 1, "R7_asr32");
    issue(3'd3, 0, 6'd8, 8'd0, 32'h1234_5680, 0, 1, "R1_ror");
    // R6 zero amount: N/Z written, C kept (C currently set)
    issue(3'd1, 0, 6'd0, 8'd0, 32'h0000_0000, 0, 1, "R6_lsl0");
    issue(3'd2, 1, 6'd0, 8'd0, 32'h9000_0000, 0, 1, "R6_byte0");
    // R5 illegal immediates, R1 illegal opcodes, right after accepted
    issue(3'd2, 0, 6'd0, 8'd0, 32'hFFFF_FFFF, 0, 1, "R5_lsr0");
    issue(3'd0, 0, 6'd33, 8'd0, 32'hFFFF_FFFF, 0, 1, "R5_asr33");
    issue(3'd1, 0, 6'd32, 8'd0, 32'h1, 0, 1, "R5_lsl32");
    issue(3'd3, 0, 6'd32, 8'd0, 32'h1, 0, 1, "R5_ror32");
    issue(3'd3, 0, 6'd0, 8'd0, 32'h1, 0, 1, "R5_ror0");
    issue(3'd6, 1, 6'd1, 8'd1, 32'h1, 0, 1, "R1_op6");
    issue(3'd5, 0, 6'd1, 8'd1, 32'h1, 0, 1, "R1_op5");
    // R3 R7 byte amounts
    issue(3'd1, 1, 6'd0, 8'd32, 32'h0000_0001, 0, 1, "R7_lslb32");
    issue(3'd1, 1, 6'd0, 8'd33, 32'hFFFF_FFFF, 0, 1, "R3_lsl33");
    issue(3'd2, 1, 6'd0, 8'd32, 32'h8000_0000, 0, 1, "R3_lsr32");
    issue(3'd2, 1, 6'd0, 8'd200, 32'hFFFF_FFFF, 0, 1, "R3_lsr200");
    issue(3'd0, 1, 6'd0, 8'd100, 32'h8000_0000, 0, 1, "R3_asr100");
    issue(3'd0, 1, 6'd0, 8'd255, 32'h4000_0000, 0, 1, "R3_asr255");
    // R4 rotate modulo
    issue(3'd3, 1, 6'd0, 8'd64, 32'hC0DE_0001, 0, 1, "R4_ror64");
    issue(3'd3, 1, 6'd0, 8'd37, 32'h0000_0010, 0, 1, "R4_ror37");
    // R8 rotate through carry; amount inputs ignored
    issue(3'd4, 0, 6'd63, 8'd9, 32'h0000_0001, 1, 1, "R8_rrx1");
    issue(3'd4, 1, 6'd0, 8'd200, 32'h8000_0002, 0, 1, "R8_rrx0");
    // R10 flags hold with set_flags low
    issue(3'd1, 0, 6'd4, 8'd0, 32'hF000_0000, 0, 0, "R10_nosf");
    issue(3'd2, 1, 6'd0, 8'd40, 32'h1234_5678, 0, 0, "R10_nosf2");
    issue(3'd4, 0, 6'd0, 8'd0, 32'h0000_0001, 1, 0, "R10_rrx");
    idle(2);
    // R2 no pulse while idle
    chk(!valid && !err, "R2", $sformatf("idle pulse actual v=%0b e=%0b expected 0/0", valid, err));
    issue(3'd0, 0, 6'd1, 8'd0, 32'h0000_0001, 0, 1, "R9_zero");
    issue(3'd2, 1, 6'd0, 8'd1, 32'h0000_0003, 0, 1, "R9_lsr1");
    idle(3);
    chk(q.size() == 0, "R2", $sformatf("pending actual %0d expected 0", q.size()));
    // R11 reset after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(result == 0 && {flag_n, flag_z, flag_c} == 3'b000 && !valid && !err, "R11",
        $sformatf("after reset actual res=%h nzc=%0b%0b%0b expected zero",
                  result, flag_n, flag_z, flag_c));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule